// File: doc/BRIEF.md
# Processor Interrupt Pin Conditioner

This block sits between a processor core's external control pins and its exception and reset logic. Pin activity reaches it as single-pin level updates. Each update names one pin by index and gives the pin's new level. The block keeps the last accepted level of every pin. It acts only when an update differs from that stored level, so a repeated write of the same level produces no event.

Each pin is read with its own sensitivity. The external interrupt and system management pins are active-high levels. The machine check pin reacts only to a falling edge and latches a sticky pending bit. Checkstop is an active-low level that halts the core. Hard reset is active low, and its falling edge gives a single-cycle core reset pulse. Soft reset is an active-high level that feeds a reset-interrupt pending bit. The pending vector and a summary request line go to the core's exception logic. The consumer clears the machine check bit with an acknowledge strobe.

Top module: `pin_cond`

## Requirements
- R1: After reset, the pending vector is 0, the summary request is low, halt is low and the core reset pulse is low. The stored levels are 1 for checkstop (index 3) and hard reset (index 4) and 0 for the other pins.
- R2: An update whose level equals the stored level of that pin changes no output. For example, a second low write to hard reset gives no second pulse, and a second low write to checkstop leaves halt set.
- R3: An accepted change on the external interrupt pin (index 0) copies its level into pending bit 0. An accepted change on the system management pin (index 1) copies its level into pending bit 1. The new value is visible after the clock edge that takes the update.
- R4: A 1-to-0 change on the machine check pin (index 2) sets pending bit 2. A 0-to-1 change on that pin has no effect.
- R5: Pending bit 2 stays set until `mck_ack_i` is high at a clock edge. If a machine check falling edge and the acknowledge arrive in the same cycle, the bit stays set.
- R6: A 1-to-0 change on checkstop (index 3) sets `halt_o`. A 0-to-1 change clears it.
- R7: A 1-to-0 change on hard reset (index 4) drives `core_rst_o` high for exactly the one cycle after the edge that takes the update. A 0-to-1 change gives no pulse.
- R8: An accepted change on the soft reset pin (index 5) copies its level into pending bit 3.
- R9: `irq_o` is high whenever any pending bit is set. It falls only once the whole pending vector is zero.
- R10: An update with a pin index of 6 or more changes no output and no stored level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| upd_vld_i | input | 1 | A pin level update is presented this cycle |
| upd_idx_i | input | IDX_W | Index of the updated pin |
| upd_lvl_i | input | 1 | New level of the updated pin |
| mck_ack_i | input | 1 | Acknowledge that clears the machine check pending bit |
| pend_o | output | 4 | Pending bits: 0 external, 1 system management, 2 machine check, 3 soft reset |
| irq_o | output | 1 | Summary interrupt request |
| halt_o | output | 1 | Core halt request from checkstop |
| core_rst_o | output | 1 | One-cycle core reset pulse |

## Verification
The assertions assume that pin updates are already synchronous to the block clock. They also assume that `upd_vld_i` and `mck_ack_i` stay low while reset is applied, because several properties look one cycle back at the update fields. The stimulus changes inputs only on the falling clock edge and holds every strobe low through reset. Its random updates cover the whole index range, including the unused indices, so the properties see legal pins and ignored pins alike.

// File: rtl/pcond_pkg.sv
// Shared constants for the pin conditioner.
// The pin and pending-bit positions are fixed, because the consumer decodes them.
package pcond_pkg;
    localparam int NUM_PINS = 6;
    localparam int PEND_W   = 4;

    // pin indices
    localparam int PIN_EXT  = 0;
    localparam int PIN_SMI  = 1;
    localparam int PIN_MCK  = 2;
    localparam int PIN_CSTP = 3;
    localparam int PIN_HRST = 4;
    localparam int PIN_SRST = 5;

    // pending-bit positions
    localparam int PB_EXT  = 0;
    localparam int PB_SMI  = 1;
    localparam int PB_MCK  = 2;
    localparam int PB_SRST = 3;

    // level each pin is taken to hold after reset (active-low pins idle high)
    localparam logic [NUM_PINS-1:0] RST_LEVELS = 6'b011000;
endpackage

// File: rtl/pcond_change_det.sv
// Stored-level register and change detector.
// It compares a single-pin update with the stored level of that pin and flags a
// rising or falling change. Indices at or above NUM_PINS match no pin.
// It assumes the updates are synchronous to clk.
module pcond_change_det
    import pcond_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_vld_i,
    input  logic [IDX_W-1:0]    upd_idx_i,
    input  logic                upd_lvl_i,
    output logic [NUM_PINS-1:0] rise_o,
    output logic [NUM_PINS-1:0] fall_o
);
    logic [NUM_PINS-1:0] lvl_q;
    logic [NUM_PINS-1:0] hit;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        // decode: this pin is addressed by the current update
        assign hit[i]    = upd_vld_i && (upd_idx_i == IDX_W'(i));
        // change flags against the stored level
        assign rise_o[i] = hit[i] &&  upd_lvl_i && !lvl_q[i];
        assign fall_o[i] = hit[i] && !upd_lvl_i &&  lvl_q[i];

        // keep the last accepted level of the pin
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_q[i] <= RST_LEVELS[i];
            else if (rise_o[i] || fall_o[i])
                lvl_q[i] <= upd_lvl_i;
        end
    end
endmodule

// File: rtl/pcond_pend_reg.sv
// Pending-interrupt register.
// The level pins follow their accepted changes. The machine check bit is set by
// a falling change and held until acknowledged, and a set wins over an acknowledge.
module pcond_pend_reg
    import pcond_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    input  logic                mck_ack_i,
    output logic [PEND_W-1:0]   pend_o
);
    logic [PEND_W-1:0] pend_q;

    // level-following bits: external, system management, soft reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q[PB_EXT]  <= 1'b0;
            pend_q[PB_SMI]  <= 1'b0;
            pend_q[PB_SRST] <= 1'b0;
        end else begin
            if (rise_i[PIN_EXT])       pend_q[PB_EXT]  <= 1'b1;
            else if (fall_i[PIN_EXT])  pend_q[PB_EXT]  <= 1'b0;
            if (rise_i[PIN_SMI])       pend_q[PB_SMI]  <= 1'b1;
            else if (fall_i[PIN_SMI])  pend_q[PB_SMI]  <= 1'b0;
            if (rise_i[PIN_SRST])      pend_q[PB_SRST] <= 1'b1;
            else if (fall_i[PIN_SRST]) pend_q[PB_SRST] <= 1'b0;
        end
    end

    // sticky machine check bit: set on a falling change, cleared by acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)
            pend_q[PB_MCK] <= 1'b0;
        else if (fall_i[PIN_MCK])
            pend_q[PB_MCK] <= 1'b1;
        else if (mck_ack_i)
            pend_q[PB_MCK] <= 1'b0;
    end

    assign pend_o = pend_q;
endmodule

// File: rtl/pcond_core_ctl.sv
// Core control outputs.
// Checkstop (active low) holds halt while it is low. A falling change on hard
// reset gives a one-cycle reset pulse.
module pcond_core_ctl
    import pcond_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] rise_i,
    input  logic [NUM_PINS-1:0] fall_i,
    output logic                halt_o,
    output logic                core_rst_o
);
    logic halt_q;
    logic crst_q;

    // halt follows the checkstop changes
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (fall_i[PIN_CSTP])
            halt_q <= 1'b1;
        else if (rise_i[PIN_CSTP])
            halt_q <= 1'b0;
    end

    // one-cycle pulse on each hard reset assertion
    always_ff @(posedge clk) begin
        if (!rst_n)
            crst_q <= 1'b0;
        else
            crst_q <= fall_i[PIN_HRST];
    end

    assign halt_o     = halt_q;
    assign core_rst_o = crst_q;
endmodule

// File: rtl/pin_cond.sv
// Processor interrupt pin conditioner, top level.
// It turns single-pin level updates into pending-interrupt bits, a summary
// request, a halt level and a core reset pulse. Updates must be synchronous to clk.
// Every output is registered or a reduction of registers, so an update takes
// effect at the clock edge that samples it.
module pin_cond
    import pcond_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_vld_i,
    input  logic [IDX_W-1:0]  upd_idx_i,
    input  logic              upd_lvl_i,
    input  logic              mck_ack_i,
    output logic [PEND_W-1:0] pend_o,
    output logic              irq_o,
    output logic              halt_o,
    output logic              core_rst_o
);
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] fall;

    pcond_change_det #(.IDX_W(IDX_W)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_vld_i (upd_vld_i),
        .upd_idx_i (upd_idx_i),
        .upd_lvl_i (upd_lvl_i),
        .rise_o    (rise),
        .fall_o    (fall)
    );

    pcond_pend_reg u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (rise),
        .fall_i    (fall),
        .mck_ack_i (mck_ack_i),
        .pend_o    (pend_o)
    );

    pcond_core_ctl u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise_i     (rise),
        .fall_i     (fall),
        .halt_o     (halt_o),
        .core_rst_o (core_rst_o)
    );

    // summary request: any pending bit
    assign irq_o = |pend_o;
endmodule

// File: rtl/pin_cond_chk.sv
// Property checker for pin_cond. It is attached by the bind statement below.
// It assumes that the update and acknowledge strobes are low while reset is applied.
module pin_cond_chk
    import pcond_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              upd_vld_i,
    input logic [IDX_W-1:0]  upd_idx_i,
    input logic              upd_lvl_i,
    input logic              mck_ack_i,
    input logic [PEND_W-1:0] pend_o,
    input logic              irq_o,
    input logic              halt_o,
    input logic              core_rst_o
);
    assert_mck_rise_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o[PB_MCK]) |->
            $past(upd_vld_i && upd_idx_i == IDX_W'(PIN_MCK) && !upd_lvl_i));

    assert_mck_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o[PB_MCK] && !mck_ack_i) |=> pend_o[PB_MCK]);

    assert_halt_set_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(halt_o) |->
            $past(upd_vld_i && upd_idx_i == IDX_W'(PIN_CSTP) && !upd_lvl_i));

    assert_halt_clr_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halt_o) |->
            $past(upd_vld_i && upd_idx_i == IDX_W'(PIN_CSTP) && upd_lvl_i));

    assert_rst_pulse_src_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |->
            $past(upd_vld_i && upd_idx_i == IDX_W'(PIN_HRST) && !upd_lvl_i));

    assert_rst_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_o |=> !core_rst_o);

    assert_bad_idx_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_vld_i && upd_idx_i >= IDX_W'(NUM_PINS) && !mck_ack_i) |=>
            ($stable(pend_o) && $stable(halt_o) && !core_rst_o));
endmodule

bind pin_cond pin_cond_chk #(.IDX_W(IDX_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .upd_vld_i  (upd_vld_i),
    .upd_idx_i  (upd_idx_i),
    .upd_lvl_i  (upd_lvl_i),
    .mck_ack_i  (mck_ack_i),
    .pend_o     (pend_o),
    .irq_o      (irq_o),
    .halt_o     (halt_o),
    .core_rst_o (core_rst_o)
);

// File: tb/pin_cond_test.sv
`timescale 1ns/1ps
module pin_cond_test;
    localparam int IDX_W = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             upd_vld_i = 1'b0;
    logic [IDX_W-1:0] upd_idx_i = '0;
    logic             upd_lvl_i = 1'b0;
    logic             mck_ack_i = 1'b0;
    logic [3:0]       pend_o;
    logic             irq_o;
    logic             halt_o;
    logic             core_rst_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // expected state, kept from the requirements
    logic [5:0] lvl_m;
    logic [3:0] pend_m;
    logic       halt_m;
    logic       crst_m;

    always #4 clk = ~clk;   // 125 MHz

    pin_cond #(.IDX_W(IDX_W)) uut (
        .clk(clk), .rst_n(rst_n), .upd_vld_i(upd_vld_i), .upd_idx_i(upd_idx_i),
        .upd_lvl_i(upd_lvl_i), .mck_ack_i(mck_ack_i), .pend_o(pend_o),
        .irq_o(irq_o), .halt_o(halt_o), .core_rst_o(core_rst_o)
    );

    // expected irq from the pending vector (R9)
    function automatic logic exp_irq(input logic [3:0] p);
        return p != 4'b0;
    endfunction

    // advance the expected state by one update
    task automatic model(input logic v, input int idx, input logic lvl, input logic ack);
        logic rise = 1'b0;
        logic fall = 1'b0;
        if (v && idx < 6) begin
            rise = lvl && !lvl_m[idx];
            fall = !lvl && lvl_m[idx];
            if (rise || fall) lvl_m[idx] = lvl;
        end
        crst_m = fall && idx == 4;
        if ((rise || fall) && idx == 0) pend_m[0] = lvl;
        if ((rise || fall) && idx == 1) pend_m[1] = lvl;
        if ((rise || fall) && idx == 5) pend_m[3] = lvl;
        if (fall && idx == 2) pend_m[2] = 1'b1;
        else if (ack)         pend_m[2] = 1'b0;
        if (fall && idx == 3) halt_m = 1'b1;
        if (rise && idx == 3) halt_m = 1'b0;
    endtask

    task automatic check(input string tag);
        n_chk++;
        if (pend_o !== pend_m || irq_o !== exp_irq(pend_m) ||
            halt_o !== halt_m || core_rst_o !== crst_m) begin
            n_bad++;
            $display("FAIL %s: pend=%b irq=%b halt=%b crst=%b expected pend=%b irq=%b halt=%b crst=%b",
                     tag, pend_o, irq_o, halt_o, core_rst_o,
                     pend_m, exp_irq(pend_m), halt_m, crst_m);
        end
    endtask

    // drive at the falling edge, let one rising edge take it, check at the next falling edge
    task automatic step(input logic v, input int idx, input logic lvl, input logic ack,
                        input string tag);
        upd_vld_i = v;
        upd_idx_i = IDX_W'(idx);
        upd_lvl_i = lvl;
        mck_ack_i = ack;
        @(posedge clk);
        model(v, idx, lvl, ack);
        @(negedge clk);
        upd_vld_i = 1'b0;
        mck_ack_i = 1'b0;
        check(tag);
    endtask

    initial begin
        #(8 * 5000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        lvl_m = 6'b011000; pend_m = '0; halt_m = 0; crst_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset state");

        // R3 and R9: external and system management levels
        step(1, 0, 1, 0, "R3 ext high, R9 irq");
        step(1, 0, 0, 0, "R3 ext low, R9 irq drop");
        step(1, 1, 1, 0, "R3 smi high");
        step(1, 1, 1, 0, "R2 smi repeat");
        step(1, 1, 0, 0, "R3 smi low");

        // R4 and R5: machine check edge and sticky bit
        step(1, 2, 1, 0, "R4 mck rise ignored");
        step(1, 2, 0, 0, "R4 mck fall sets");
        step(0, 0, 0, 0, "R5 mck held");
        step(1, 2, 0, 0, "R2 mck low repeat");
        step(0, 0, 0, 1, "R5 mck ack clears");
        step(1, 2, 1, 0, "R4 mck rise again");
        step(1, 2, 0, 1, "R5 set wins over ack");
        step(0, 0, 0, 1, "R5 ack after collision");

        // R6: checkstop
        step(1, 3, 1, 0, "R2 checkstop idle high repeat");
        step(1, 3, 0, 0, "R6 checkstop low halts");
        step(1, 3, 0, 0, "R2 checkstop repeat low");
        step(1, 3, 1, 0, "R6 checkstop high resumes");

        // R7: hard reset pulse
        step(1, 4, 0, 0, "R7 hreset fall pulse");
        step(0, 0, 0, 0, "R7 pulse ends");
        step(1, 4, 0, 0, "R2 hreset repeat no pulse");
        step(1, 4, 1, 0, "R7 hreset rise no pulse");

        // R8 and R9: soft reset and the summary
        step(1, 5, 1, 0, "R8 sreset high");
        step(1, 0, 1, 0, "R9 two pending");
        step(1, 5, 0, 0, "R8 sreset low, R9 irq held");
        step(1, 0, 0, 0, "R9 irq drops");

        // R10: indices outside the pin set
        step(1, 6, 1, 0, "R10 index 6");
        step(1, 7, 0, 0, "R10 index 7");
        step(1, 7, 1, 0, "R10 index 7 high");

        // constrained random mix
        void'($urandom(32'd20240611));
        for (int k = 0; k < 600; k++) begin
            int idx = int'($urandom_range(0, 7));
            logic lvl = logic'($urandom_range(0, 1));
            logic ack = ($urandom_range(0, 7) == 0);
            logic v = ($urandom_range(0, 4) != 0);
            step(v, idx, lvl, ack, "random R2 R3 R4 R5 R6 R7 R8 R9 R10");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule